// File: doc/BRIEF.md
# Iterative Round-Robin Crossbar Match Scheduler

This block computes, once per cell slot, which input of an N-by-N input-queued cell switch may send to which output. The caller presents a flat N×N request matrix, in which bit `i*N + j` is set when input `i` has at least one queued cell for output `j`, and pulses `start`. The block then runs a fixed number of request/grant/accept rounds, one per clock. In each round every unmatched output grants one of the unmatched inputs that request it, and every unmatched input accepts one of the grants it receives.

Each output owns a round-robin grant pointer and each input owns a round-robin accept pointer. Both kinds of pointer survive from slot to slot, so contention is spread over time. When the rounds are complete the block raises a one-cycle `done`. For every input it then shows whether that input was matched and which output it was given. These results stay on the outputs until the next slot is started.

Top module: `rrm_sched`

## Requirements
- R1: After reset `done` is low, every `matchValid` bit is low, and every grant pointer and accept pointer holds index 0.
- R2: When `start` is sampled high at rising edge t while the block is idle, the matrix is captured at edge t. `done` is then high for exactly one cycle, the cycle that follows edge t+ITER.
- R3: A `start` pulse sampled while a slot is in progress is ignored, and so is the matrix presented with it. The result of the running slot is unaffected.
- R4: In each round, every unmatched output with at least one requesting unmatched input grants exactly one of them. It picks the first such input found going upward from its grant pointer, with the search wrapping from N-1 to 0.
- R5: An output that grants sets its grant pointer to one past the granted input, modulo N. It does this whether or not the input accepts. An output that grants nobody keeps its pointer.
- R6: In each round, every unmatched input with at least one grant accepts exactly one. It picks the first granting output found going upward from its accept pointer, with wrap-around.
- R7: An input that accepts sets its accept pointer to one past the accepted output, modulo N. An input that accepts nothing keeps its pointer.
- R8: At the start of every slot all ports are unmatched. An input or output matched in one round takes no part in the later rounds of that slot, so a request left unserved in round one can still be matched in round two.
- R9: When `done` is high, no output is assigned to more than one input, and every matched pair (i, j) had bit `i*N + j` set in the captured matrix.
- R10: `matchValid[i]` flags input i as matched. The index of its output is in `matchOut[i*PW +: PW]`, where PW = max(1, ceil(log2 N)). Both are held unchanged from `done` until the next accepted `start`.
- R11: Grant and accept pointers carry over from one slot to the next and are not reinitialised by `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a slot; ignored while busy |
| reqMatrix | input | N*N | Request bit for input i, output j at position i*N+j |
| done | output | 1 | One-cycle pulse when the match is ready |
| matchValid | output | N | Per input: matched in this slot |
| matchOut | output | N*PW | Per input: index of the matched output |

## Verification
A fixed walk-through from the reset state pins exact grant and accept choices. Two follow-up slots then separate the two pointer kinds: in one, every input asks for the same output, which shows the grant pointer moved past the input it granted. In the other, a single input asks for every output, which shows the accept pointer moved independently. A few thousand pseudo-random request matrices are then compared, slot by slot, against an arithmetic model that carries its own pointers across slots. This catches errors in wrap-around, in the update of pointers whose grant was refused, and in excluding matched ports from the second round. An extra `start` injected mid-slot with a different matrix shows that busy-time requests are discarded.

// File: rtl/rrm_pkg.sv
package rrm_pkg;
  typedef struct packed {
    logic load;     // capture matrix, clear match state
    logic iterate;  // perform one request/grant/accept round
    logic last;     // current round is the final one
  } rrmStrobe_t;
endpackage

// File: rtl/rrm_rrarb.sv
module rrm_rrarb #(
  parameter int N  = 4,
  parameter int PW = 2
) (
  input  logic [N-1:0]  reqVec,
  input  logic [PW-1:0] ptr,
  output logic          hit,
  output logic [PW-1:0] idx,
  output logic [PW-1:0] nextPtr
);
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int k = 0; k < N; k++) begin
      if (!hit && reqVec[(int'(ptr) + k) % N]) begin
        hit = 1'b1;
        idx = PW'((int'(ptr) + k) % N);
      end
    end
    nextPtr = (int'(idx) == N - 1) ? '0 : idx + PW'(1);
  end
endmodule

// File: rtl/rrm_ctrl.sv
module rrm_ctrl
  import rrm_pkg::*;
#(
  parameter int ITER = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  output rrmStrobe_t strobe,
  output logic       busy,
  output logic       done
);
  localparam int CW = (ITER > 1) ? $clog2(ITER) : 1;

  logic [CW-1:0] iterCnt;

  always_comb begin
    strobe.load    = start & ~busy;
    strobe.iterate = busy;
    strobe.last    = busy && (iterCnt == CW'(ITER - 1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      iterCnt <= '0;
      done    <= 1'b0;
    end else begin
      done <= strobe.last;
      if (strobe.load) begin
        busy    <= 1'b1;
        iterCnt <= '0;
      end else if (strobe.last) begin
        busy <= 1'b0;
      end else if (strobe.iterate) begin
        iterCnt <= iterCnt + CW'(1);
      end
    end
  end
endmodule

// File: rtl/rrm_datapath.sv
module rrm_datapath
  import rrm_pkg::*;
#(
  parameter int N  = 4,
  parameter int PW = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  rrmStrobe_t      strobe,
  input  logic [N*N-1:0]  reqIn,
  output logic [N*N-1:0]  reqHeld,
  output logic [N-1:0]    inMatched,
  output logic [N*PW-1:0] matchOut
);
  logic [N-1:0]  outMatched;
  logic [PW-1:0] gPtr [N];
  logic [PW-1:0] aPtr [N];

  logic [N-1:0]  colReq [N];   // per output: live requests by input
  logic [N-1:0]  rowGnt [N];   // per input: grants by output
  logic          gHit   [N];
  logic [PW-1:0] gIdx   [N];
  logic [PW-1:0] gNext  [N];
  logic          aHit   [N];
  logic [PW-1:0] aIdx   [N];
  logic [PW-1:0] aNext  [N];

  always_comb begin
    for (int j = 0; j < N; j++)
      for (int i = 0; i < N; i++)
        colReq[j][i] = reqHeld[i*N + j] & ~inMatched[i] & ~outMatched[j];
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        rowGnt[i][j] = gHit[j] && (int'(gIdx[j]) == i);
  end

  for (genvar j = 0; j < N; j++) begin : g_grant
    rrm_rrarb #(.N(N), .PW(PW)) u_garb (
      .reqVec(colReq[j]), .ptr(gPtr[j]),
      .hit(gHit[j]), .idx(gIdx[j]), .nextPtr(gNext[j])
    );
  end

  for (genvar i = 0; i < N; i++) begin : g_accept
    rrm_rrarb #(.N(N), .PW(PW)) u_aarb (
      .reqVec(rowGnt[i]), .ptr(aPtr[i]),
      .hit(aHit[i]), .idx(aIdx[i]), .nextPtr(aNext[i])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqHeld    <= '0;
      inMatched  <= '0;
      outMatched <= '0;
      matchOut   <= '0;
      for (int k = 0; k < N; k++) begin
        gPtr[k] <= '0;
        aPtr[k] <= '0;
      end
    end else if (strobe.load) begin
      reqHeld    <= reqIn;
      inMatched  <= '0;
      outMatched <= '0;
      matchOut   <= '0;
    end else if (strobe.iterate) begin
      for (int j = 0; j < N; j++)
        if (gHit[j]) gPtr[j] <= gNext[j];
      for (int i = 0; i < N; i++)
        if (aHit[i]) begin
          aPtr[i]              <= aNext[i];
          inMatched[i]         <= 1'b1;
          outMatched[aIdx[i]]  <= 1'b1;
          matchOut[i*PW +: PW] <= aIdx[i];
        end
    end
  end
endmodule

// File: rtl/rrm_sched.sv
module rrm_sched
  import rrm_pkg::*;
#(
  parameter int N    = 4,
  parameter int ITER = (N > 1) ? $clog2(N) : 1,
  localparam int PW  = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic [N*N-1:0]  reqMatrix,
  output logic            done,
  output logic [N-1:0]    matchValid,
  output logic [N*PW-1:0] matchOut
);
  rrmStrobe_t     strobe;
  logic           busy;
  logic [N*N-1:0] reqHeld;

  rrm_ctrl #(.ITER(ITER)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .strobe(strobe), .busy(busy), .done(done)
  );

  rrm_datapath #(.N(N), .PW(PW)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqIn(reqMatrix),
    .reqHeld(reqHeld), .inMatched(matchValid), .matchOut(matchOut)
  );
endmodule

// File: rtl/rrm_sched_chk.sv
module rrm_sched_chk #(
  parameter int N  = 4,
  parameter int PW = 2
) (
  input logic            clk,
  input logic            rstN,
  input logic            start,
  input logic            busy,
  input logic            done,
  input logic [N-1:0]    matchValid,
  input logic [N*PW-1:0] matchOut,
  input logic [N*N-1:0]  reqHeld
);
  logic [N-1:0] useVec [N];

  always_comb
    for (int j = 0; j < N; j++)
      for (int i = 0; i < N; i++)
        useVec[j][i] = matchValid[i] && (int'(matchOut[i*PW +: PW]) == j);

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R2
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R3
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(reqHeld));

  // R10
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> ($stable(matchValid) && $stable(matchOut)));

  for (genvar j = 0; j < N; j++) begin : g_out
    // R9
    one_to_one_chk: assert property (@(posedge clk) disable iff (!rstN)
      done |-> ($countones(useVec[j]) <= 1));
  end

  for (genvar i = 0; i < N; i++) begin : g_in
    // R9
    requested_chk: assert property (@(posedge clk) disable iff (!rstN)
      (done && matchValid[i]) |-> reqHeld[i*N + int'(matchOut[i*PW +: PW])]);
  end
endmodule

bind rrm_sched rrm_sched_chk #(.N(N), .PW(PW)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done),
  .matchValid(matchValid), .matchOut(matchOut), .reqHeld(reqHeld)
);

// File: tb/rrm_sched_tb.sv
module rrm_sched_tb;
  localparam int N = 4;
  localparam int ITER = 2;
  localparam int PW = 2;
  localparam time CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [N*N-1:0] reqMatrix = '0;
  logic done;
  logic [N-1:0] matchValid;
  logic [N*PW-1:0] matchOut;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  int gp[N];
  int ap[N];

  always #(CLK_PERIOD/2) clk = ~clk;

  rrm_sched #(.N(N), .ITER(ITER)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .reqMatrix(reqMatrix),
    .done(done), .matchValid(matchValid), .matchOut(matchOut)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int outIdx(input int i);
    return int'(matchOut[i*PW +: PW]);
  endfunction

  // Arithmetic model of one slot; updates gp/ap
  task automatic modelSlot(input logic [N*N-1:0] m, output bit eVld[N], output int eIdx[N]);
    bit inM[N];
    bit outM[N];
    int g[N];
    for (int i = 0; i < N; i++) begin inM[i] = 0; outM[i] = 0; eVld[i] = 0; eIdx[i] = 0; end
    for (int it = 0; it < ITER; it++) begin
      for (int j = 0; j < N; j++) begin
        g[j] = -1;
        if (!outM[j])
          for (int k = 0; k < N; k++) begin
            int c = (gp[j] + k) % N;
            if (g[j] < 0 && m[c*N + j] && !inM[c]) g[j] = c;
          end
      end
      for (int j = 0; j < N; j++) if (g[j] >= 0) gp[j] = (g[j] + 1) % N;
      for (int i = 0; i < N; i++) begin
        int a = -1;
        if (!inM[i])
          for (int k = 0; k < N; k++) begin
            int c = (ap[i] + k) % N;
            if (a < 0 && g[c] == i) a = c;
          end
        if (a >= 0) begin
          ap[i] = (a + 1) % N; inM[i] = 1; outM[a] = 1; eVld[i] = 1; eIdx[i] = a;
        end
      end
    end
  endtask

  task automatic runSlot(input logic [N*N-1:0] m, input bit inject, input logic [N*N-1:0] injM);
    bit eVld[N];
    int eIdx[N];
    bit dutResid;
    bit expResid;
    int use_[N];
    modelSlot(m, eVld, eIdx);
    @(negedge clk); reqMatrix = m; start = 1'b1;
    for (int k = 1; k <= ITER; k++) begin
      @(negedge clk);
      if (k == 1 && inject) begin start = 1'b1; reqMatrix = injM; end
      else start = 1'b0;
      check(done == 1'b0, "R2 done early", int'(done), 0);
    end
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b1, "R2 done timing", int'(done), 1);
    for (int i = 0; i < N; i++) begin
      check(matchValid[i] == eVld[i], "R4/R6/R8/R11 valid", int'(matchValid[i]), int'(eVld[i]));
      if (eVld[i]) check(outIdx(i) == eIdx[i], "R5/R7/R11 index", outIdx(i), eIdx[i]);
    end
    for (int j = 0; j < N; j++) use_[j] = 0;
    dutResid = 0; expResid = 0;
    for (int i = 0; i < N; i++)
      if (matchValid[i]) begin
        use_[outIdx(i)]++;
        check(m[i*N + outIdx(i)] == 1'b1, "R9 unrequested pair", i, outIdx(i));
      end
    for (int j = 0; j < N; j++) check(use_[j] <= 1, "R9 one-to-one", use_[j], 1);
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        bit dOut = 0;
        bit eOut = 0;
        for (int q = 0; q < N; q++) begin
          if (matchValid[q] && outIdx(q) == j) dOut = 1;
          if (eVld[q] && eIdx[q] == j) eOut = 1;
        end
        if (m[i*N + j] && !matchValid[i] && !dOut) dutResid = 1;
        if (m[i*N + j] && !eVld[i] && !eOut) expResid = 1;
      end
    check(!dutResid || expResid, "R8 residual request", int'(dutResid), int'(expResid));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] heldV;
    logic [N*PW-1:0] heldO;
    logic [31:0] lcg;
    for (int k = 0; k < N; k++) begin gp[k] = 0; ap[k] = 0; end
    repeat (3) @(negedge clk);
    // R1 reset state
    check(done == 1'b0, "R1 done after reset", int'(done), 0);
    check(matchValid == '0, "R1 matchValid after reset", int'(matchValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(done == 1'b0 && matchValid == '0, "R1 idle after release", int'(matchValid), 0);

    // R1 R4 R6: walk-through from reset pointers; in0->{o0,o1}, in2->{o3}
    runSlot(16'h0003 | 16'h0800, 1'b0, '0);
    check(matchValid == 4'b0101, "R4 walk-through valid", int'(matchValid), 5);
    check(outIdx(0) == 0, "R6 in0 accepts o0", outIdx(0), 0);
    check(outIdx(2) == 3, "R4 in2 gets o3", outIdx(2), 3);

    // R10 results held while idle
    heldV = matchValid; heldO = matchOut;
    repeat (3) @(negedge clk);
    check(matchValid == heldV && matchOut == heldO, "R10 hold", int'(matchOut), int'(heldO));

    // R5 R11: all inputs want o1; o1 pointer moved to 1 -> grants in1
    runSlot(16'h2222, 1'b0, '0);
    check(matchValid == 4'b0010 && outIdx(1) == 1, "R5 grant pointer", int'(matchValid), 2);

    // R7 R11: in0 wants every output; accept pointer 1 -> o1
    runSlot(16'h000F, 1'b0, '0);
    check(matchValid[0] && outIdx(0) == 1, "R7 accept pointer", outIdx(0), 1);

    // R3: start with a different matrix mid-slot is ignored
    runSlot(16'h8000, 1'b1, 16'h0001);
    check(matchValid == 4'b1000 && outIdx(3) == 3, "R3 busy start ignored", int'(matchValid), 8);

    // R8: full matrix needs both rounds
    runSlot(16'hFFFF, 1'b0, '0);

    // sweep
    lcg = 32'h1234_5678;
    for (int s = 0; s < 4000; s++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      runSlot(lcg[23:8], (s % 37) == 5, lcg[31:16]);
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule